// File: doc/BRIEF.md
# Versioned Context Save/Restore Unit

This unit sits at the foot of one column of reconfigurable logic. It moves the register state of a task between the column's serial scan chain and a small context store inside the unit. Each column has its own unit and its own store, and all columns work in parallel. A command names a slot and chooses save or restore. The unit then runs the whole transfer without further help: one bit per clock, for the full length of the chain.

Every save stamps its slot with a version tag. The new tag is one higher than the tag the slot held before the save. A restore command carries the version the scheduler believes is current. If the stored tag differs, the unit raises an error pulse and does not shift, so a stale context never reaches the chain. A combinational read port shows the data and the tag of any slot, so that software can copy a saved context to a central store.

Top module: `ctxsr_top`

## Requirements
- R1: After reset, busy, done, err and scan_en are low, and every slot reads data 0 and version 0.
- R2: A save with a slot below SLOTS (10) is accepted only while the unit is idle. scan_en and busy are high for exactly N consecutive cycles, starting in the cycle after the command. The scan_in bit sampled in shift cycle k (counting from 0) becomes bit k of the stored word, so the first bit lands in the LSB.
- R3: done is high for exactly one cycle, the cycle after the last shift cycle. busy and scan_en are low in that cycle. A new command is accepted from the next cycle onward.
- R4: Each completed save sets the slot's version to its previous value plus one, modulo 2^VER_W. No other slot changes.
- R5: A restore whose cmd_ver equals the slot's stored version drives bit k of the stored word on scan_out in shift cycle k. The stored data and version stay unchanged. scan_out is 0 whenever a restore is not shifting, and during a save.
- R6: A restore whose cmd_ver differs from the stored version raises err for exactly one cycle, the cycle after the command. In that case busy, scan_en and done stay low and the slot is unchanged.
- R7: A command of either kind with slot 10 or more is rejected in the same way as R6, and no slot changes.
- R8: A command presented while busy or done is high is ignored. The running transfer completes normally and no second transfer follows.
- R9: rd_data and rd_ver show the contents of slot rd_slot combinationally. For rd_slot 10 or more, both read as 0.
- R10: The version tag wraps from 2^VER_W-1 to 0, and a restore that expects 0 is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_save | input | 1 | 1 = save chain to slot, 0 = restore slot to chain |
| cmd_slot | input | SLOT_W (4) | Slot index |
| cmd_ver | input | VER_W (8) | Expected version for a restore |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| scan_en | output | 1 | Scan chain shift enable |
| scan_in | input | 1 | Serial data coming from the chain (save) |
| scan_out | output | 1 | Serial data going to the chain (restore) |
| rd_slot | input | SLOT_W (4) | Read port slot index |
| rd_data | output | N (16) | Read port context data |
| rd_ver | output | VER_W (8) | Read port version tag |

## Verification
The bench saves distinct patterns into every slot, including all-zero and all-one words, in two rounds. It then restores each slot and compares every serial bit. This catches a reversed bit order or a shift count that is off by one. Restores with a version one above or one below the stored tag, and commands naming slots 10 to 15, must produce only the error pulse and leave every slot intact; a design that checked the tag too late would corrupt the chain or the store. A command injected in mid-transfer must not retarget or restart the running transfer. Driving one slot through 256 saves shows whether the tag wraps to zero or sticks.

// File: rtl/ctxsr_pkg.sv
package ctxsr_pkg;
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_FIN} seq_state_t;

  // next version tag, modulo 2^w (w is the caller's width)
  function automatic logic [31:0] ver_next(input logic [31:0] v, input int w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction

  function automatic logic slot_ok(input logic [31:0] s, input int slots);
    return s < 32'(slots);
  endfunction
endpackage

// File: rtl/ctxsr_store.sv
module ctxsr_store
  import ctxsr_pkg::*;
#(
  parameter int N      = 16,
  parameter int SLOTS  = 10,
  parameter int VER_W  = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [N-1:0]      wr_data,
  input  logic [SLOT_W-1:0] a_slot,
  output logic [N-1:0]      a_data,
  output logic [VER_W-1:0]  a_ver,
  input  logic [SLOT_W-1:0] b_slot,
  output logic [N-1:0]      b_data,
  output logic [VER_W-1:0]  b_ver
);
  localparam int ENTRIES = 2 ** SLOT_W;

  logic [N-1:0]     data_q [ENTRIES];
  logic [VER_W-1:0] ver_q  [ENTRIES];

  for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
    if (s < SLOTS) begin : g_real
      logic hit;
      assign hit = wr_en && (wr_slot == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[s] <= '0;
          ver_q[s]  <= '0;
        end else if (hit) begin
          data_q[s] <= wr_data;
          ver_q[s]  <= VER_W'(ver_next(32'(ver_q[s]), VER_W));
        end
      end
    end else begin : g_none
      assign data_q[s] = '0;
      assign ver_q[s]  = '0;
    end
  end

  assign a_data = data_q[a_slot];
  assign a_ver  = ver_q[a_slot];
  assign b_data = data_q[b_slot];
  assign b_ver  = ver_q[b_slot];
endmodule

// File: rtl/ctxsr_seq.sv
module ctxsr_seq
  import ctxsr_pkg::*;
#(
  parameter int N      = 16,
  parameter int SLOTS  = 10,
  parameter int VER_W  = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_save,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [VER_W-1:0]  cmd_ver,
  input  logic [N-1:0]      cur_data,
  input  logic [VER_W-1:0]  cur_ver,
  input  logic              scan_in,
  output logic              scan_en,
  output logic              scan_out,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              accept,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [N-1:0]      wr_data
);
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [N-1:0]      sreg_q;
  logic              save_q;
  logic [SLOT_W-1:0] slot_q;
  logic              err_q;
  logic              reject;
  logic              last;

  assign reject = !slot_ok(32'(cmd_slot), SLOTS) ||
                  (!cmd_save && (cur_ver != cmd_ver));
  assign accept = (state_q == S_IDLE) && cmd_valid && !reject;
  assign last   = (cnt_q == CNT_W'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sreg_q  <= '0;
      save_q  <= 1'b0;
      slot_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          if (reject) begin
            err_q <= 1'b1;
          end else begin
            state_q <= S_SHIFT;
            cnt_q   <= '0;
            save_q  <= cmd_save;
            slot_q  <= cmd_slot;
            sreg_q  <= cmd_save ? '0 : cur_data;
          end
        end
        S_SHIFT: begin
          sreg_q <= {save_q & scan_in, sreg_q[N-1:1]};
          cnt_q  <= cnt_q + CNT_W'(1);
          if (last) state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == S_SHIFT);
  assign scan_en  = busy;
  assign done     = (state_q == S_FIN);
  assign err      = err_q;
  assign scan_out = busy && !save_q && sreg_q[0];
  assign wr_en    = busy && save_q && last;
  assign wr_slot  = slot_q;
  assign wr_data  = {scan_in, sreg_q[N-1:1]};
endmodule

// File: rtl/ctxsr_top.sv
module ctxsr_top
  import ctxsr_pkg::*;
#(
  parameter int N      = 16,
  parameter int SLOTS  = 10,
  parameter int VER_W  = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_save,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [VER_W-1:0]  cmd_ver,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              scan_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [N-1:0]      rd_data,
  output logic [VER_W-1:0]  rd_ver
);
  logic              save_commit;
  logic              cmd_accept;
  logic [SLOT_W-1:0] commit_slot;
  logic [N-1:0]      commit_data;
  logic [N-1:0]      cur_data;
  logic [VER_W-1:0]  cur_ver;

  ctxsr_store #(.N(N), .SLOTS(SLOTS), .VER_W(VER_W), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(save_commit), .wr_slot(commit_slot), .wr_data(commit_data),
    .a_slot(cmd_slot), .a_data(cur_data), .a_ver(cur_ver),
    .b_slot(rd_slot), .b_data(rd_data), .b_ver(rd_ver)
  );

  ctxsr_seq #(.N(N), .SLOTS(SLOTS), .VER_W(VER_W), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_save(cmd_save), .cmd_slot(cmd_slot),
    .cmd_ver(cmd_ver), .cur_data(cur_data), .cur_ver(cur_ver),
    .scan_in(scan_in), .scan_en(scan_en), .scan_out(scan_out),
    .busy(busy), .done(done), .err(err), .accept(cmd_accept),
    .wr_en(save_commit), .wr_slot(commit_slot), .wr_data(commit_data)
  );
endmodule

// File: rtl/ctxsr_chk.sv
module ctxsr_chk #(
  parameter int N = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic err,
  input logic scan_en,
  input logic scan_out,
  input logic save_commit,
  input logic cmd_accept
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (scan_en)  run_cnt <= run_cnt + 32'd1;
    else if (done)     run_cnt <= '0;
  end

  // R2
  shift_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_cnt == 32'(N));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy && !scan_en);

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !scan_en && !done && $past(cmd_valid));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_accept) && $past(!done));

  // R4
  commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_commit |=> done);

  // R5
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !scan_out);
endmodule

bind ctxsr_top ctxsr_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .done(done), .err(err), .scan_en(scan_en), .scan_out(scan_out),
  .save_commit(save_commit), .cmd_accept(cmd_accept)
);

// File: tb/sim_ctxsr_top.sv
`timescale 1ns/1ps
module sim_ctxsr_top;
  localparam int N = 16, SLOTS = 10, VER_W = 8, SLOT_W = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_save = 0, scan_in = 0;
  logic [SLOT_W-1:0] cmd_slot = 0, rd_slot = 0;
  logic [VER_W-1:0] cmd_ver = 0;
  logic busy, done, err, scan_en, scan_out;
  logic [N-1:0] rd_data;
  logic [VER_W-1:0] rd_ver;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [N-1:0] exp_data [SLOTS];
  int exp_ver [SLOTS];

  always #5 clk = ~clk;

  ctxsr_top #(.N(N), .SLOTS(SLOTS), .VER_W(VER_W), .SLOT_W(SLOT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_save(cmd_save),
    .cmd_slot(cmd_slot), .cmd_ver(cmd_ver), .busy(busy), .done(done),
    .err(err), .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .rd_slot(rd_slot), .rd_data(rd_data), .rd_ver(rd_ver));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_slot(input int s, input string req);
    rd_slot = SLOT_W'(s);
    #1;
    if (s < SLOTS) begin
      chk(rd_data == exp_data[s], req, int'(rd_data), int'(exp_data[s]));
      chk(int'(rd_ver) == exp_ver[s], req, int'(rd_ver), exp_ver[s]);
    end else begin
      chk(rd_data == 0 && rd_ver == 0, req, int'(rd_data) | int'(rd_ver), 0);
    end
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < SLOTS; s++) check_slot(s, req);
  endtask

  task automatic op(input bit save, input int slot, input int ver,
                    input logic [N-1:0] data, input bit intrude);
    bit good;
    logic [N-1:0] word;
    good = (slot < SLOTS) && (save || (ver == exp_ver[slot]));
    word = (slot < SLOTS) ? exp_data[slot] : '0;
    @(negedge clk);
    cmd_valid = 1; cmd_save = save; cmd_slot = SLOT_W'(slot); cmd_ver = VER_W'(ver);
    @(negedge clk);
    cmd_valid = 0;
    if (!good) begin
      chk(err == 1, (slot >= SLOTS) ? "R7 err" : "R6 err", int'(err), 1);
      chk(!busy && !scan_en && !done, "R6 no transfer", int'(busy | scan_en | done), 0);
      @(negedge clk);
      chk(err == 0 && !busy, "R6 err one cycle", int'(err), 0);
      return;
    end
    for (int i = 0; i < N; i++) begin
      chk(scan_en && busy, "R2 shift enable", int'(scan_en), 1);
      if (save) chk(scan_out == 0, "R5 out quiet on save", int'(scan_out), 0);
      else chk(scan_out == word[i], "R5 restore bit", int'(scan_out), int'(word[i]));
      scan_in = data[i];
      if (intrude && i == 3) begin
        cmd_valid = 1; cmd_save = 1; cmd_slot = 0;
      end
      if (intrude && i == 4) cmd_valid = 0;
      @(negedge clk);
    end
    chk(done && !busy && !scan_en, "R3 done pulse", int'({done, busy, scan_en}), 4);
    if (intrude) begin
      cmd_valid = 1; cmd_save = 1; cmd_slot = 0;
    end
    if (save) begin
      exp_data[slot] = data;
      exp_ver[slot] = (exp_ver[slot] + 1) % (1 << VER_W);
    end
    @(negedge clk);
    cmd_valid = 0;
    chk(!done && !busy && !scan_en, "R8 no second transfer", int'({done, busy, scan_en}), 0);
  endtask

  initial begin
    for (int s = 0; s < SLOTS; s++) begin exp_data[s] = 0; exp_ver[s] = 0; end
    #1;
    check_all("R1 reset contents");
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!busy && !done && !err && !scan_en, "R1 reset outputs",
        int'({busy, done, err, scan_en}), 0);
    check_slot(12, "R9 out-of-range read");
    check_slot(15, "R9 out-of-range read");

    // never-saved slot restores zeros with version 0; version 1 refused
    op(0, 4, 0, '0, 0);
    op(0, 4, 1, '0, 0);
    check_all("R6 store intact");

    // two save rounds over every slot
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < SLOTS; s++) begin
        logic [N-1:0] d;
        d = 16'hA5C3 ^ (16'(s) * 16'h1111) ^ (r != 0 ? 16'hFFFF : 16'h0000);
        if (s == 3) d = (r == 0) ? 16'h0000 : 16'hFFFF;
        op(1, s, 0, d, 0);
        check_slot(s, "R4 save data and version");
      end
    check_all("R4 slot isolation");

    // restores with correct version, then off-by-one versions
    for (int s = 0; s < SLOTS; s++) begin
      op(0, s, exp_ver[s], '0, 0);
      check_slot(s, "R5 restore leaves slot");
      op(0, s, exp_ver[s] + 1, '0, 0);
      op(0, s, exp_ver[s] - 1, '0, 0);
    end
    check_all("R6 mismatch leaves store");

    // out-of-range slots, both commands
    for (int s = SLOTS; s < 16; s++) begin
      op(1, s, 0, 16'h1234, 0);
      op(0, s, 0, '0, 0);
    end
    check_all("R7 rejected slots leave store");

    // command injected mid-transfer
    op(1, 5, 0, 16'h0F0F, 1);
    check_all("R8 intrusion ignored");
    op(0, 5, exp_ver[5], '0, 1);
    check_all("R8 intrusion ignored on restore");

    // version wrap on slot 9
    while (exp_ver[9] != 0) op(1, 9, 0, 16'(exp_ver[9] * 16'h0101), 0);
    chk(rd_ver == 0, "R10 wrap to zero", int'(rd_ver), 0);
    check_slot(9, "R10 wrap slot");
    op(0, 9, 0, '0, 0);
    op(0, 9, 255, '0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule